// File: doc/BRIEF.md
# Two-wire slave command-byte decoder

This block is the receiving front end of a slave on a two-wire serial bus of the I2C kind. Both bus lines are brought into the system clock domain through a synchroniser chain. The block watches them for start and stop conditions and shifts in the first byte that follows each start, most significant bit first. It does not treat that byte as a seven-bit address with a direction bit. The upper four bits must match a fixed selector pattern, bit 3 is an output-enable flag, and the low three bits choose the command.

When the byte is acceptable, the block pulls SDA low for the acknowledge slot through an open-drain enable. After the slot it hands the command and the flag to downstream logic with a single-cycle strobe. Any other byte is left unanswered, and the rest of the transaction is ignored.

Beside the decoder sit two pieces of state. One is a volatile 8-bit identity register that downstream assignment logic loads. The other is a byte-wise view of a fixed 48-bit serial number that arrives on a constant input.

Top module: `twi_cmd_front`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The eight bits that follow a start are sampled on SCL rising edges and assembled most significant bit first, so bit 7 is the first bit on the wire.
- R2: A byte whose bits 7:4 differ from binary 0110 is not acknowledged and produces no command strobe.
- R3: The command field in bits 2:0 is legal only for 000 (fuse), 001 (read), 010 (write), 100 (assign) and 110 (clear). A byte carrying 011, 101 or 111 is not acknowledged and produces no strobe.
- R4: `sda_oe_o` goes high only at the SCL falling edge that ends the eighth bit of an acceptable byte. It stays high through the ninth SCL pulse and drops at the ninth falling edge. It is never high at any other time.
- R5: After the acknowledge slot, `cmd_valid_o` pulses high for exactly one clock. In that same cycle `cmd_code_o` shows bits 2:0 and `out_en_o` shows bit 3 of the accepted byte. `out_en_o` holds its value until the next accepted byte.
- R6: A new start at any point drops the partly received byte and begins a fresh byte. A stop at any point drops it without a strobe.
- R7: Once the control byte and its acknowledge slot are over, further bits in the same transaction are ignored until the next start: they get no acknowledge and no strobe.
- R8: The identity register `id_o` is 0x00 after reset. It takes `id_wdata_i` on each clock where `id_we_i` is high.
- R9: `ser_byte_o` shows serial byte k, which is `serial_i[8k+7:8k]`, when `ser_sel_i` equals k for k from 0 to 5. It shows 0x00 when `ser_sel_i` is 6 or 7.
- R10: After reset `sda_oe_o`, `cmd_valid_o` and `out_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_code_o | output | 3 | Command field of the last accepted byte |
| out_en_o | output | 1 | Registered output-enable flag for the external enable pin |
| id_we_i | input | 1 | Load strobe for the identity register |
| id_wdata_i | input | ID_W | Value to load into the identity register |
| id_o | output | ID_W | Identity register contents |
| serial_i | input | SN_W | Fixed serial number |
| ser_sel_i | input | SEL_W | Serial byte index |
| ser_byte_o | output | 8 | Selected serial byte |

## Verification
The bench builds the block with three synchroniser stages instead of the default two. The selector stays at its default 0110 and the serial number at its default width of six bytes. The extra stage lengthens the delay from pad to acknowledge and from pad to release, which tests whether the ACK still covers the ninth SCL-high phase. The bench's window model tolerates the larger latency without any cycle-exact knowledge of the chain. The six-byte serial width makes selector values 6 and 7 out of range, so the zero output for an unused index can be reached.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;
  localparam int CMD_W  = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_FUSE   = 3'b000,
    CMD_READ   = 3'b001,
    CMD_WRITE  = 3'b010,
    CMD_ASSIGN = 3'b100,
    CMD_CLEAR  = 3'b110
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_BYTE8,
    ST_ACK,
    ST_SKIP
  } fsm_e;

  function automatic logic cmd_is_legal(input logic [CMD_W-1:0] c);
    case (c)
      CMD_FUSE, CMD_READ, CMD_WRITE, CMD_ASSIGN, CMD_CLEAR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ctrl_byte_ok(input logic [BYTE_W-1:0] b,
                                        input logic [CODE_W-1:0] code);
    return (b[BYTE_W-1 -: CODE_W] == code) && cmd_is_legal(b[CMD_W-1:0]);
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int   STAGES  = 2,
  parameter int   LINES   = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prev_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
      else        pipe <= {pipe[STAGES-1:0], d_i[g]};
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign prev_o[g] = pipe[STAGES];
  end

endmodule

// File: rtl/twi_ctrl_fsm.sv
module twi_ctrl_fsm
  import twi_cmd_pkg::*;
#(
  parameter logic [CODE_W-1:0] CTRL_CODE = 4'b0110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             scl_prev,
  input  logic             sda_lvl,
  input  logic             sda_prev,
  output logic             sda_oe_o,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_code_o,
  output logic             out_en_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  fsm_e              state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;

  // Named bus events, visible to the assertions below
  logic scl_rise, scl_fall, start_evt, stop_evt, byte_full, byte_ok;
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
  assign byte_full = (state == ST_BYTE8);
  assign byte_ok   = ctrl_byte_ok(shreg, CTRL_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      sda_oe_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= '0;
      out_en_o    <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (start_evt) begin
        state    <= ST_SHIFT;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            if (bit_cnt == LAST_BIT) state <= ST_BYTE8;
            else                     bit_cnt <= bit_cnt + 1'b1;
          end
          ST_BYTE8: if (scl_fall) begin
            if (byte_ok) begin
              state    <= ST_ACK;
              sda_oe_o <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ACK: if (scl_fall) begin
            sda_oe_o    <= 1'b0;
            cmd_valid_o <= 1'b1;
            cmd_code_o  <= shreg[CMD_W-1:0];
            out_en_o    <= shreg[CMD_W];
            state       <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R5
  cmd_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(sda_oe_o));

  // R4
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> ($past(scl_fall) && $past(byte_full)));

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o && !scl_fall && !start_evt && !stop_evt) |=> sda_oe_o);

  // R2
  ack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> (shreg[BYTE_W-1 -: CODE_W] == CTRL_CODE));

  // R3
  ack_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> cmd_is_legal(shreg[CMD_W-1:0]));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_SHIFT && bit_cnt == '0 && !sda_oe_o));

endmodule

// File: rtl/twi_cmd_front.sv
module twi_cmd_front
  import twi_cmd_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] CTRL_CODE   = 4'b0110,
  parameter int                ID_W        = 8,
  parameter int                SN_W        = 48,
  localparam int               SN_BYTES    = SN_W / BYTE_W,
  localparam int               SEL_W       = $clog2(SN_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_code_o,
  output logic              out_en_o,
  input  logic              id_we_i,
  input  logic [ID_W-1:0]   id_wdata_i,
  output logic [ID_W-1:0]   id_o,
  input  logic [SN_W-1:0]   serial_i,
  input  logic [SEL_W-1:0]  ser_sel_i,
  output logic [BYTE_W-1:0] ser_byte_o
);

  logic [1:0] line_lvl, line_prev;

  twi_line_sync #(.STAGES(SYNC_STAGES), .LINES(2), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({scl_i, sda_i}),
    .lvl_o  (line_lvl),
    .prev_o (line_prev)
  );

  twi_ctrl_fsm #(.CTRL_CODE(CTRL_CODE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (line_lvl[1]),
    .scl_prev    (line_prev[1]),
    .sda_lvl     (line_lvl[0]),
    .sda_prev    (line_prev[0]),
    .sda_oe_o    (sda_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o),
    .out_en_o    (out_en_o)
  );

  // Volatile identity register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       id_o <= '0;
    else if (id_we_i) id_o <= id_wdata_i;
  end

  // Byte view of the fixed serial number
  always_comb begin
    ser_byte_o = '0;
    for (int k = 0; k < SN_BYTES; k++)
      if (ser_sel_i == SEL_W'(k)) ser_byte_o = serial_i[k*BYTE_W +: BYTE_W];
  end

  // R8
  id_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_we_i |=> (id_o == $past(id_wdata_i)));

endmodule

// File: tb/twi_cmd_front_tb.sv
module twi_cmd_front_tb;

  localparam int CLK_PERIOD = 10;
  localparam int H = 8;  // system clocks per SCL half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_bus;
  logic        sda_oe, cmd_valid, out_en;
  logic [2:0]  cmd_code;
  logic        id_we = 1'b0;
  logic [7:0]  id_wdata = 8'h00;
  logic [7:0]  id_q;
  logic [47:0] serial = 48'hC3_5A_17_E8_90_2D;
  logic [2:0]  ser_sel = 3'd0;
  logic [7:0]  ser_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit ack_allowed = 1'b0;
  bit prev_valid = 1'b0;
  logic last_oe = 1'b0;
  logic [3:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain bus: either side can pull low
  assign sda_bus = m_sda & ~sda_oe;

  twi_cmd_front #(.SYNC_STAGES(3)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .cmd_valid_o (cmd_valid),
    .cmd_code_o  (cmd_code),
    .out_en_o    (out_en),
    .id_we_i     (id_we),
    .id_wdata_i  (id_wdata),
    .id_o        (id_q),
    .serial_i    (serial),
    .ser_sel_i   (ser_sel),
    .ser_byte_o  (ser_byte)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-clock reference: ACK window and command strobes (R4, R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (sda_oe && !ack_allowed) begin
        failures++;
        $display("FAIL R4 sda_oe outside ACK window: actual=1 expected=0");
      end
      if (cmd_valid) begin
        checks++;
        if (prev_valid) begin
          failures++;
          $display("FAIL R5 strobe longer than one cycle: actual=1 expected=0");
        end else if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R5 unexpected strobe: actual=%0h expected=none",
                   {out_en, cmd_code});
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          if ({out_en, cmd_code} !== e) begin
            failures++;
            $display("FAIL R5 strobe payload: actual=%0h expected=%0h",
                     {out_en, cmd_code}, e);
          end
        end
      end
      prev_valid = cmd_valid;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    if (!scl) begin
      m_sda = 1'b1; wait_clk(H);
      scl = 1'b1;   wait_clk(H);
    end
    m_sda = 1'b0; wait_clk(H);
    scl = 1'b0;   wait_clk(H);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    m_sda = 1'b1; wait_clk(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_clk(H);
    scl = 1'b1; wait_clk(H);
    scl = 1'b0;
  endtask

  task automatic read_ack(output logic got);
    m_sda = 1'b1; wait_clk(H);
    scl = 1'b1;   wait_clk(H/2);
    got = sda_bus; wait_clk(H/2);
    scl = 1'b0;
  endtask

  function automatic bit ref_accept(input logic [7:0] b);
    return (b[7:4] == 4'b0110) &&
           (b[2:0] inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b110});
  endfunction

  task automatic txn(input logic [7:0] b, input bit extra, input string req);
    bit   exp_ack;
    logic got;
    exp_ack = ref_accept(b);
    if (exp_ack) begin
      exp_q.push_back({b[3], b[2:0]});
      last_oe = b[3];
    end
    do_start();
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    ack_allowed = exp_ack;
    read_ack(got);
    chk(req, "ack slot level", got, exp_ack ? 1'b0 : 1'b1);
    wait_clk(6);
    ack_allowed = 1'b0;
    chk("R4", "sda released after ninth pulse", sda_oe, 1'b0);
    if (extra) begin
      for (int i = 7; i >= 0; i--) send_bit(8'h61 >> i);
      read_ack(got);
      chk("R7", "second byte not acknowledged", got, 1'b1);
    end
    do_stop();
    wait_clk(10);
    chk("R5", "pending strobes delivered", exp_q.size(), 0);
    chk("R5", "out_en holds last accepted flag", out_en, last_oe);
  endtask

  initial begin
    wait_clk(3);
    chk("R10", "sda_oe after reset", sda_oe, 1'b0);
    chk("R10", "cmd_valid after reset", cmd_valid, 1'b0);
    chk("R10", "out_en after reset", out_en, 1'b0);
    chk("R8", "id after reset", id_q, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);

    // R9: serial byte view, including unused indices
    for (int k = 0; k < 8; k++) begin
      ser_sel = 3'(k);
      wait_clk(1);
      chk("R9", "serial byte", ser_byte, (k < 6) ? ((serial >> (8*k)) & 48'hFF) : 0);
    end

    // R8: identity register loads
    id_wdata = 8'hA5; id_we = 1'b1; wait_clk(1); id_we = 1'b0; wait_clk(1);
    chk("R8", "id load A5", id_q, 8'hA5);
    id_wdata = 8'h3C; wait_clk(2);
    chk("R8", "id unchanged without strobe", id_q, 8'hA5);
    id_we = 1'b1; wait_clk(1); id_we = 1'b0; wait_clk(1);
    chk("R8", "id load 3C", id_q, 8'h3C);

    // R1/R5: every legal command, both flag values
    txn(8'h61, 1'b0, "R1");
    txn(8'h68, 1'b0, "R5");
    txn(8'h6A, 1'b0, "R5");
    txn(8'h64, 1'b0, "R5");
    txn(8'h6E, 1'b0, "R5");
    txn(8'h60, 1'b0, "R5");
    txn(8'h6C, 1'b0, "R5");
    // R1: bit-reversed 0x61 must be rejected (MSB first)
    txn(8'h86, 1'b0, "R1");
    // R2: wrong selector codes
    txn(8'h59, 1'b0, "R2");
    txn(8'hE9, 1'b0, "R2");
    // R3: unlisted command values
    txn(8'h6B, 1'b0, "R3");
    txn(8'h65, 1'b0, "R3");
    txn(8'h6F, 1'b0, "R3");
    // R7: extra byte after the control byte
    txn(8'h62, 1'b1, "R7");

    // R6: restart mid-byte, then a full accepted byte
    do_start();
    for (int i = 7; i >= 4; i--) send_bit(8'h6A >> i);
    txn(8'h69, 1'b0, "R6");

    // R6: stop mid-byte gives no strobe
    do_start();
    for (int i = 7; i >= 3; i--) send_bit(8'h61 >> i);
    do_stop();
    wait_clk(20);
    chk("R6", "no strobe after aborted byte", exp_q.size(), 0);
    chk("R6", "out_en kept after abort", out_en, last_oe);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule